// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front-End

This block is the slave side of a three-wire serial EEPROM with a 2 Kbit array. It runs on a fast system clock and samples the chip-select, serial-clock and serial-data-in lines. A serial-clock rising edge is recognised on the first system clock edge that sees the serial clock high after seeing it low while chip select is high. After a start bit it gathers a 2-bit opcode, an address field and, for write-type commands, a data field. It then either shifts array contents out on the data output or, when chip select falls, raises a single-cycle request toward the write/erase cycle controller.

An organization input chooses 16-bit words or 8-bit bytes, and this sets the widths of the address and data fields. Reads stream successive locations for as long as the serial clock keeps running. A clock-pulse counter runs from the start bit to the falling edge of chip select. Any command that would change the array, or change the write-enable latch, is dropped without effect unless that count is exactly the expected frame length.

Top module: `mw_eeprom_front`

## Requirements
- R1: While `rst_n` is low no frame is accepted, `dout` and `req_valid` stay 0, and the write-enable latch is cleared, so a write sent right after reset is ignored.
- R2: While `cs` is high, serial-clock rises with `di`=0 before the start bit are ignored. The first rise with `di`=1 is the start bit. The next two bits form the opcode, MSB first: 10 read, 01 write, 11 erase, 00 extended.
- R3: With `org`=1 the address field is 8 bits and the data field is 16 bits. With `org`=0 they are 9 bits and 8 bits. Both fields are sent MSB first, so a byte-mode write is exactly 20 clocks.
- R4: Extended commands are decoded from the two most significant address-field bits: 00 disables writes, 01 writes all, 10 erases all, 11 enables writes.
- R5: Write, erase, write-all and erase-all produce a request only while the write-enable latch is set.
- R6: The expected clock count, start bit included, is 3+A+D for write and write-all and 3+A for every other non-read command (A and D are the field widths). On any other count the command has no effect: no request, and no change to the enable latch.
- R7: An accepted modifying command raises `req_valid` for exactly one cycle, on the first system clock edge that sees `cs` low. It carries `req_op` (0 write, 1 erase, 2 write-all, 3 erase-all), the raw address field on `req_addr` (bit 8 is 0 in word mode), the data field right-aligned on `req_data` (0 for erase commands), and `req_byte`=!`org`.
- R8: For a read, the serial-clock rise that carries the last address bit drives `dout` to 0 (a dummy bit). Each later rise drives the next data bit, MSB first.
- R9: A read streams successive locations without further dummy bits. Word addresses use the low 7 address bits and wrap from 127 to 0. Byte addresses use 8 bits and wrap from 255 to 0. Byte address bit 0 = 1 selects the high byte of `mem_rdata`, and `mem_addr` is the byte address shifted right by one.
- R10: Whenever `cs` is low, `dout` is 0 from the next clock edge and any partial frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, held low until power is valid |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| mem_rdata | input | 16 | Array word at `mem_addr` |
| mem_addr | output | 7 | Array word address for reads |
| dout | output | 1 | Serial data out |
| req_valid | output | 1 | One-cycle modify request |
| req_op | output | 2 | Request kind |
| req_addr | output | 9 | Address field of the request |
| req_data | output | 16 | Data field of the request |
| req_byte | output | 1 | Request uses byte organization |

## Verification
The embedded assertions check on every cycle that a request appears only after chip select has dropped, only while writes are enabled, and only as a single-cycle pulse. They also check that the enable latch moves only at the end of a frame, that the read dummy bit is 0, and that the output is quiet while deselected. Only the bench's scenarios can show correct field widths in each organization, the exact-count rejection of frames that are one clock long or short, the extended-command decoding, and the data order and address wrap of sequential reads. For these it compares against a behavioural model on every clock.

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int DEPTH_W = 7,
  parameter int CW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               sk,
  input  logic               di,
  input  logic               org,
  input  logic [DW-1:0]      mem_rdata,
  output logic [DEPTH_W-1:0] mem_addr,
  output logic               dout,
  output logic               req_valid,
  output logic [1:0]         req_op,
  output logic [AW:0]        req_addr,
  output logic [DW-1:0]      req_data,
  output logic               req_byte
);
  localparam int RBW = $clog2(DW);
  localparam int HW  = DW / 2;
  localparam logic [CW-1:0] AEND_W = CW'(3 + AW);
  localparam logic [CW-1:0] AEND_B = CW'(4 + AW);
  localparam logic [CW-1:0] FULL_W = CW'(3 + AW + DW);
  localparam logic [CW-1:0] FULL_B = CW'(4 + AW + HW);
  localparam logic [1:0] OP_EXT = 2'b00, OP_WRITE = 2'b01, OP_READ = 2'b10, OP_ERASE = 2'b11;

  logic sk_q, cs_q, started, reading, wen;
  logic [CW-1:0]  cnt;
  logic [1:0]     op;
  logic [AW:0]    addr_sh;
  logic [DW-1:0]  data_sh, shreg;
  logic [RBW-1:0] rbit;
  logic [DEPTH_W:0] ptr;

  wire sk_rise = cs & sk & ~sk_q;
  wire cs_fall = cs_q & ~cs;
  wire [CW-1:0] aend = org ? AEND_W : AEND_B;
  wire [1:0] ext = org ? addr_sh[AW-1:AW-2] : addr_sh[AW:AW-1];
  wire long_frame = (op == OP_WRITE) || (op == OP_EXT && ext == 2'b01);
  wire [CW-1:0] exp_len = long_frame ? (org ? FULL_W : FULL_B) : aend;
  wire len_ok = started && (cnt == exp_len);
  wire modify = (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_EXT && ext[1] != ext[0]);
  wire [AW:0] addr_full = {addr_sh[AW-1:0], di};
  wire [DW-1:0] word_sel = org ? mem_rdata
                               : {(ptr[0] ? mem_rdata[DW-1:HW] : mem_rdata[HW-1:0]), {HW{1'b0}}};
  wire [DEPTH_W:0] ptr_inc = org ? {1'b0, ptr[DEPTH_W-1:0] + 1'b1} : ptr + 1'b1;
  wire [DEPTH_W:0] ptr_start = org ? {1'b0, addr_full[DEPTH_W-1:0]} : addr_full[DEPTH_W:0];
  wire [RBW-1:0] last_bit = org ? RBW'(DW - 1) : RBW'(HW - 1);

  assign mem_addr = org ? ptr[DEPTH_W-1:0] : ptr[DEPTH_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0; cs_q <= 1'b0; started <= 1'b0; reading <= 1'b0; wen <= 1'b0;
      cnt <= '0; op <= '0; addr_sh <= '0; data_sh <= '0; shreg <= '0; rbit <= '0; ptr <= '0;
      dout <= 1'b0; req_valid <= 1'b0; req_op <= '0; req_addr <= '0; req_data <= '0; req_byte <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      req_valid <= 1'b0;
      if (cs_fall && len_ok) begin
        if (op == OP_EXT && ext == 2'b11) wen <= 1'b1;
        if (op == OP_EXT && ext == 2'b00) wen <= 1'b0;
        if (modify && wen) begin
          req_valid <= 1'b1;
          req_op    <= (op == OP_WRITE) ? 2'd0 : (op == OP_ERASE) ? 2'd1 : (ext == 2'b01) ? 2'd2 : 2'd3;
          req_addr  <= addr_sh;
          req_data  <= data_sh;
          req_byte  <= ~org;
        end
      end
      if (!cs) begin
        started <= 1'b0;
        reading <= 1'b0;
        dout    <= 1'b0;
      end else if (sk_rise) begin
        if (!started) begin
          if (di) begin
            started <= 1'b1; cnt <= CW'(1); op <= '0; addr_sh <= '0; data_sh <= '0;
          end
        end else begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          if (cnt < CW'(3))     op <= {op[0], di};
          else if (cnt < aend)  addr_sh <= addr_full;
          else                  data_sh <= {data_sh[DW-2:0], di};
          if (reading) begin
            if (rbit == '0) begin
              dout  <= word_sel[DW-1];
              shreg <= {word_sel[DW-2:0], 1'b0};
              rbit  <= last_bit;
              ptr   <= ptr_inc;
            end else begin
              dout  <= shreg[DW-1];
              shreg <= {shreg[DW-2:0], 1'b0};
              rbit  <= rbit - 1'b1;
            end
          end else if (op == OP_READ && cnt == aend - 1'b1) begin
            reading <= 1'b1;
            dout    <= 1'b0;
            rbit    <= '0;
            ptr     <= ptr_start;
          end
        end
      end
    end
  end

  a_r7_req_after_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(cs));
  a_r7_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wen));
  a_r6_enable_moves_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> ($past(cs_q) && !$past(cs)));
  a_r8_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reading) |-> !dout);
  a_r10_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout);
endmodule

// File: tb/tb_mw_eeprom_front.sv
module tb_mw_eeprom_front;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic [15:0] mem_rdata;
  logic [6:0]  mem_addr;
  logic dout, req_valid, req_byte;
  logic [1:0]  req_op;
  logic [8:0]  req_addr;
  logic [15:0] req_data;
  logic [15:0] mem [128];

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  mw_eeprom_front dut (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .dout(dout), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_byte(req_byte));

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_wen = 0, m_started = 0, m_reading = 0;
  int m_cnt = 0, m_ptr = 0, m_pos = 0;
  int m_bits[$];
  logic exp_dout = 0, exp_rv = 0, exp_byte = 0;
  logic [1:0] exp_op = 0;
  logic [8:0] exp_addr = 0;
  logic [15:0] exp_data = 0;

  function automatic int af(); return org ? 8 : 9; endfunction
  function automatic int df(); return org ? 16 : 8; endfunction

  function automatic int field(int from, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | m_bits[from + i];
    return v;
  endfunction

  function automatic logic mem_bit(int p, int pos);
    logic [15:0] w;
    logic [7:0] b;
    if (org) begin
      w = mem[p % 128];
      return w[15 - pos];
    end
    w = mem[(p / 2) % 128];
    b = (p % 2 == 1) ? w[15:8] : w[7:0];
    return b[7 - pos];
  endfunction

  task automatic fail(input string what, input int act, input int exp);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic model_edge(input logic b);
    if (!rst_n) return;
    if (!m_started) begin
      if (b) begin m_started = 1; m_cnt = 1; m_bits.delete(); end
      return;
    end
    m_cnt++;
    m_bits.push_back(int'(b));
    if (m_reading) begin
      exp_dout = mem_bit(m_ptr, m_pos);
      m_pos++;
      if (m_pos == df()) begin
        m_pos = 0;
        m_ptr = org ? (m_ptr + 1) % 128 : (m_ptr + 1) % 256;
      end
    end else if (m_bits.size() == 2 + af() && field(0, 2) == 2) begin
      m_reading = 1;
      exp_dout = 0;
      m_ptr = org ? field(2, af()) % 128 : field(2, af()) % 256;
      m_pos = 0;
    end
  endtask

  task automatic model_cs_fall();
    int op, a, ext, len;
    bit has_data;
    if (rst_n && m_started && m_cnt >= 3 + af()) begin
      op = field(0, 2);
      a = field(2, af());
      ext = a >> (af() - 2);
      has_data = (op == 1) || (op == 0 && ext == 1);
      len = 3 + af() + (has_data ? df() : 0);
      if (op != 2 && m_cnt == len) begin
        if (m_wen && (op == 1 || op == 3 || (op == 0 && (ext == 1 || ext == 2)))) begin
          exp_rv = 1;
          exp_op = (op == 1) ? 2'd0 : (op == 3) ? 2'd1 : (ext == 1) ? 2'd2 : 2'd3;
          exp_addr = 9'(a);
          exp_data = has_data ? 16'(field(2 + af(), df())) : 16'h0;
          exp_byte = !org;
        end
        if (op == 0 && ext == 3) m_wen = 1;
        if (op == 0 && ext == 0) m_wen = 0;
      end
    end
    m_started = 0;
    m_reading = 0;
    exp_dout = 0;
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (dout !== exp_dout) fail("dout", int'(dout), int'(exp_dout));
      total++;
      if (req_valid !== exp_rv) fail("req_valid", int'(req_valid), int'(exp_rv));
      if (exp_rv && req_valid === 1'b1) begin
        total++; if (req_op !== exp_op) fail("req_op", int'(req_op), int'(exp_op));
        total++; if (req_addr !== exp_addr) fail("req_addr", int'(req_addr), int'(exp_addr));
        total++; if (req_data !== exp_data) fail("req_data", int'(req_data), int'(exp_data));
        total++; if (req_byte !== exp_byte) fail("req_byte", int'(req_byte), int'(exp_byte));
      end
    end
  end

  task automatic sk_pulse(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); sk = 1'b1;
    @(posedge clk); #1 model_edge(b);
    @(negedge clk); sk = 1'b0;
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0;
    @(posedge clk); #1 model_cs_fall();
    @(posedge clk); #1 exp_rv = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) sk_pulse(v[i]);
  endtask

  task automatic do_cmd(input int op, input int a, input int d, input bit has_data,
                        input int delta, input int lead);
    logic [31:0] v;
    int n;
    v = 32'd1;
    v = (v << 2) | 32'(op);
    v = (v << af()) | 32'(a);
    n = 3 + af();
    if (has_data) begin v = (v << df()) | 32'(d); n += df(); end
    cs_on();
    repeat (lead) sk_pulse(1'b0);
    if (delta < 0) send(n + delta, v >> (-delta));
    else begin send(n, v); repeat (delta) sk_pulse(1'b0); end
    cs_off();
  endtask

  task automatic ext_cmd(input int code, input int delta);
    do_cmd(0, code << (af() - 2), 16'hA5C3, code == 1, delta, 0);
  endtask

  task automatic do_read(input int a, input int nbits);
    logic [31:0] v;
    v = (32'd1 << 2) | 32'd2;
    v = (v << af()) | 32'(a);
    cs_on();
    send(3 + af(), v);
    repeat (nbits) sk_pulse(1'b0);
    cs_off();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    total++;
    fail("watchdog", 0, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'((i * 16'h0123) ^ 16'h5AC3);
    tag = "R1";
    repeat (3) @(negedge clk);
    ext_cmd(3, 0);
    total++; if (dout !== 1'b0) fail("dout in reset", int'(dout), 0);
    total++; if (req_valid !== 1'b0) fail("req in reset", int'(req_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_cmd(1, 8'h12, 16'h1111, 1, 0, 0);

    tag = "R2";
    do_cmd(0, 3 << 6, 0, 0, 0, 3);
    do_cmd(1, 8'h5A, 16'hBEEF, 1, 0, 2);

    tag = "R7";
    do_cmd(3, 8'h33, 0, 0, 0, 0);
    ext_cmd(1, 0);
    ext_cmd(2, 0);
    do_cmd(1, 8'hC7, 16'h8001, 1, 0, 0);

    tag = "R6";
    do_cmd(1, 8'h44, 16'h2222, 1, 1, 0);
    do_cmd(1, 8'h44, 16'h2222, 1, -1, 0);
    do_cmd(3, 8'h21, 0, 0, 1, 0);
    ext_cmd(1, -1);
    ext_cmd(2, 2);

    tag = "R3";
    @(negedge clk); org = 1'b0;
    do_cmd(1, 9'h1A5, 8'h3C, 1, 0, 0);
    do_cmd(1, 9'h1A5, 8'h3C, 1, 1, 0);
    do_cmd(3, 9'h0FF, 0, 0, 0, 0);
    ext_cmd(1, 0);
    ext_cmd(2, 0);

    tag = "R4";
    ext_cmd(0, 0);
    do_cmd(1, 9'h010, 8'h77, 1, 0, 0);
    @(negedge clk); org = 1'b1;
    do_cmd(3, 8'h10, 0, 0, 0, 0);
    ext_cmd(3, 1);
    do_cmd(1, 8'h10, 16'h7777, 1, 0, 0);

    tag = "R5";
    ext_cmd(3, 0);
    do_cmd(1, 8'h10, 16'h7777, 1, 0, 0);
    ext_cmd(0, 0);
    ext_cmd(2, 0);

    tag = "R8/R9";
    do_read(8'h05, 20);
    do_read(8'h7E, 48);
    do_read(8'hFE, 40);
    @(negedge clk); org = 1'b0;
    do_read(9'h0FE, 24);
    do_read(9'h133, 30);

    tag = "R10";
    @(negedge clk); org = 1'b1;
    do_read(8'h20, 7);
    do_read(8'h21, 18);
    cs_on();
    send(3, 3'b101);
    cs_off();
    do_cmd(1, 8'h01, 16'h0001, 1, 0, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule